// File: doc/BRIEF.md
# Transfer-Unit Packetizer with Throttle

This block frames the packed symbol stream of one active video line into fixed-length transfer units for a serial display link. Each clock moves one 16-bit word, which is two 8-bit link symbols. A transfer unit spans 64 symbol times on every lane. With the selected lane count, that is 32, 64 or 128 words of the packed stream. Inside each unit the granted data words come first. The rest of the unit is fill: a fill-start marker, zero stuffing, and a fill-end marker that always closes the unit. When a unit is completely filled with data it carries no markers.

A fractional throttle decides how many data words each unit may carry, so that the payload is spread evenly across the line rather than sent as it arrives. The per-unit payload is an integer part plus an 8-bit fraction. An accumulator adds the fraction once per unit and grants one extra word each time it carries. The accumulator restarts at every line start. Configuration is captured at line start.

Input data is pulled with a ready/valid pair. When the source has no word while the throttle is granting one, the block pauses instead of inventing data, and it raises a sticky underflow flag. The word that carries line end closes the current unit with fill. The block then waits, idle, for the next line start.

Top module: `tu_packetizer`

## Requirements
- R1: After reset, out_valid, in_ready and underflow are low. Whenever out_valid is low, out_data and out_ctrl are zero.
- R2: The unit length in words is 32, 64 or 128 for lane_sel 0, 1 and 2. lane_sel 3 behaves as 2. The output of every line is a whole number of units.
- R3: Count the units of a line from k=0. Unit k carries `ratio_int + floor((k+1)*ratio_frac/256) - floor(k*ratio_frac/256)` data words, after the limit of R4 is applied, unless the line ends sooner.
- R4: Let T be the unit length and M the marker length. A grant of T or more gives a full unit with no markers. A grant between T-2M+1 and T-1 is reduced to T-2M.
- R5: After the data of a unit, the first M words are fill-start markers: out_data 16'hF7F7, out_ctrl 2'b11. The last M words of the unit are fill-end markers: 16'hFBFB, out_ctrl 2'b11. Any words between them are zero with out_ctrl 2'b00. Fill-end wins where the two overlap. M is 1 for lane_sel 0 and 1, and 2 otherwise. out_ctrl bit 0 flags the low byte and bit 1 the high byte.
- R6: Accepted data words appear unchanged, in order, with out_ctrl 2'b00, on the cycle after acceptance.
- R7: in_ready is high only during the data part of a unit. A cycle where in_ready is high and in_valid is low produces no output word and does not advance the unit.
- R8: underflow is set by any cycle of R7's stall. It stays set until line_start clears it.
- R9: The word accepted with line_end is followed by fill up to the end of its unit. After that, out_valid and in_ready stay low until the next line_start.
- R10: ratio_int, ratio_frac and lane_sel are sampled on line_start. Changes to them during a line have no effect on that line.
- R11: The throttle accumulator restarts at every line_start, so each line's unit sequence depends only on that line's configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Pulse that starts a line and captures the configuration |
| lane_sel | input | 2 | Lane count select: 0 gives 1 lane, 1 gives 2 lanes, 2 or 3 give 4 lanes |
| ratio_int | input | INT_W | Integer part of data words per unit |
| ratio_frac | input | FRAC_W | Fractional part of data words per unit |
| in_data | input | 16 | Two packed data symbols |
| in_valid | input | 1 | in_data holds a word |
| line_end | input | 1 | Marks the last word of the line, qualified by acceptance |
| in_ready | output | 1 | The block accepts a word this cycle |
| out_data | output | 16 | Two output symbols |
| out_ctrl | output | 2 | Per-byte control flag |
| out_valid | output | 1 | An output word is present |
| underflow | output | 1 | Sticky: data was missing while a slot was granted |

## Verification
The bound checker watches every cycle. It checks that every unit ends in a fill-end marker when it is not full, and that a stall never produces an output word. It checks that underflow is set by a stall and holds until line start, that in_ready never returns once fill has started within a unit, that every grant fits its unit, and that the output is quiet while out_valid is low. Only the bench's scenarios can show the things that depend on a whole line. These are the exact payload of each unit under the fractional throttle, the lane-dependent unit and marker lengths, the clamp near a full unit, the closing of the final partial unit, and that a mid-line configuration change is ignored. The bench compares each whole line against a sequence it builds itself.

// File: rtl/tu_pkg.sv
package tu_pkg;

  typedef enum logic [1:0] {
    W_DATA  = 2'd0,
    W_FS    = 2'd1,
    W_STUFF = 2'd2,
    W_FE    = 2'd3
  } word_kind_e;

  // Lane count from the 2-bit select.
  function automatic int lanes_of(logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  // Words of the packed stream in one unit (two symbols per word).
  function automatic int tu_words_of(int syms, int lanes);
    return (syms * lanes) / 2;
  endfunction

  // Words taken by one fill marker: one symbol time over all lanes, at least one word.
  function automatic int marker_of(int lanes);
    return (lanes >= 4) ? 2 : 1;
  endfunction

  // Keep a grant that leaves room for both markers, or make the unit full.
  function automatic int clamp_grant(int g, int tw, int m);
    if (g >= tw) return tw;
    if (g > tw - 2 * m) return tw - 2 * m;
    return g;
  endfunction

  // Kind of a fill word from its place in the unit and in the fill.
  function automatic word_kind_e fill_kind(int pos, int fidx, int tw, int m);
    if (pos >= tw - m) return W_FE;
    if (fidx < m) return W_FS;
    return W_STUFF;
  endfunction

endpackage

// File: rtl/tu_throttle.sv
module tu_throttle
  import tu_pkg::*;
#(
  parameter int TU_SYMS = 64,
  parameter int INT_W   = 8,
  parameter int FRAC_W  = 8,
  parameter int POS_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              advance,
  input  logic [1:0]        lane_in,
  input  logic [INT_W-1:0]  int_in,
  input  logic [FRAC_W-1:0] frac_in,
  output logic [POS_W-1:0]  grant,
  output logic [POS_W-1:0]  tw,
  output logic [1:0]        mk
);

  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;
  int lanes_n, tw_n, mk_n, g_start, g_adv;

  assign sum = {1'b0, acc_q} + {1'b0, frac_q};

  always_comb begin
    lanes_n = lanes_of(lane_in);
    tw_n    = tu_words_of(TU_SYMS, lanes_n);
    mk_n    = marker_of(lanes_n);
    g_start = clamp_grant(int'(int_in), tw_n, mk_n);
    g_adv   = clamp_grant(int'(int_q) + int'(sum[FRAC_W]), int'(tw), int'(mk));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q  <= '0;
      frac_q <= '0;
      acc_q  <= '0;
      grant  <= '0;
      tw     <= POS_W'(TU_SYMS / 2);
      mk     <= 2'd1;
    end else if (start) begin
      int_q  <= int_in;
      frac_q <= frac_in;
      acc_q  <= frac_in;
      grant  <= POS_W'(g_start);
      tw     <= POS_W'(tw_n);
      mk     <= 2'(mk_n);
    end else if (advance) begin
      acc_q  <= sum[FRAC_W-1:0];
      grant  <= POS_W'(g_adv);
    end
  end

endmodule

// File: rtl/tu_sequencer.sv
module tu_sequencer
  import tu_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             in_valid,
  input  logic             line_end,
  input  logic [POS_W-1:0] grant,
  input  logic [POS_W-1:0] tw,
  input  logic [1:0]       mk,
  output logic             in_ready,
  output logic             emit,
  output word_kind_e       kind,
  output logic             tu_last,
  output logic             advance,
  output logic             fill_emit,
  output logic [POS_W-1:0] pos,
  output logic             underflow
);

  logic             active_q, ended_q;
  logic [POS_W-1:0] dcnt_q, fidx_q;
  logic             data_phase, take, stall, finish;

  assign data_phase = active_q && !ended_q && (dcnt_q < grant);
  assign in_ready   = data_phase;
  assign take       = data_phase && in_valid;
  assign stall      = data_phase && !in_valid;
  assign emit       = active_q && !stall;
  assign fill_emit  = emit && !take;
  assign tu_last    = (pos == tw - POS_W'(1));
  assign finish     = emit && tu_last && (ended_q || (take && line_end));
  assign advance    = emit && tu_last && !finish;

  always_comb begin
    if (take) kind = W_DATA;
    else      kind = fill_kind(int'(pos), int'(fidx_q), int'(tw), int'(mk));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      ended_q   <= 1'b0;
      pos       <= '0;
      dcnt_q    <= '0;
      fidx_q    <= '0;
      underflow <= 1'b0;
    end else if (start) begin
      active_q  <= 1'b1;
      ended_q   <= 1'b0;
      pos       <= '0;
      dcnt_q    <= '0;
      fidx_q    <= '0;
      underflow <= 1'b0;
    end else begin
      if (stall) underflow <= 1'b1;
      if (emit) begin
        if (take) begin
          dcnt_q <= dcnt_q + POS_W'(1);
          if (line_end) ended_q <= 1'b1;
        end else begin
          fidx_q <= fidx_q + POS_W'(1);
        end
        if (tu_last) begin
          pos    <= '0;
          dcnt_q <= '0;
          fidx_q <= '0;
          if (finish) active_q <= 1'b0;
        end else begin
          pos <= pos + POS_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/tu_framer.sv
module tu_framer
  import tu_pkg::*;
#(
  parameter logic [7:0] FS_CODE = 8'hF7,
  parameter logic [7:0] FE_CODE = 8'hFB
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        emit,
  input  word_kind_e  kind,
  input  logic [15:0] in_data,
  output logic        out_valid,
  output logic [15:0] out_data,
  output logic [1:0]  out_ctrl
);

  logic [15:0] d_n;
  logic [1:0]  c_n;

  always_comb begin
    case (kind)
      W_DATA:  begin d_n = in_data;            c_n = 2'b00; end
      W_FS:    begin d_n = {FS_CODE, FS_CODE}; c_n = 2'b11; end
      W_FE:    begin d_n = {FE_CODE, FE_CODE}; c_n = 2'b11; end
      default: begin d_n = '0;                 c_n = 2'b00; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ctrl  <= '0;
    end else begin
      out_valid <= emit;
      out_data  <= emit ? d_n : '0;
      out_ctrl  <= emit ? c_n : '0;
    end
  end

endmodule

// File: rtl/tu_packetizer.sv
module tu_packetizer
  import tu_pkg::*;
#(
  parameter int         TU_SYMS = 64,
  parameter int         INT_W   = 8,
  parameter int         FRAC_W  = 8,
  parameter logic [7:0] FS_CODE = 8'hF7,
  parameter logic [7:0] FE_CODE = 8'hFB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [1:0]        lane_sel,
  input  logic [INT_W-1:0]  ratio_int,
  input  logic [FRAC_W-1:0] ratio_frac,
  input  logic [15:0]       in_data,
  input  logic              in_valid,
  input  logic              line_end,
  output logic              in_ready,
  output logic [15:0]       out_data,
  output logic [1:0]        out_ctrl,
  output logic              out_valid,
  output logic              underflow
);

  localparam int MAX_TW = TU_SYMS * 2;
  localparam int POS_W  = $clog2(MAX_TW + 1);

  logic [POS_W-1:0] grant_w, tw_w, pos_w;
  logic [1:0]       mk_w;
  logic             emit_w, tu_last_w, advance_w, fill_emit_w;
  word_kind_e       kind_w;

  tu_throttle #(
    .TU_SYMS(TU_SYMS), .INT_W(INT_W), .FRAC_W(FRAC_W), .POS_W(POS_W)
  ) u_throttle (
    .clk(clk), .rst_n(rst_n), .start(line_start), .advance(advance_w),
    .lane_in(lane_sel), .int_in(ratio_int), .frac_in(ratio_frac),
    .grant(grant_w), .tw(tw_w), .mk(mk_w)
  );

  tu_sequencer #(.POS_W(POS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(line_start), .in_valid(in_valid),
    .line_end(line_end), .grant(grant_w), .tw(tw_w), .mk(mk_w),
    .in_ready(in_ready), .emit(emit_w), .kind(kind_w), .tu_last(tu_last_w),
    .advance(advance_w), .fill_emit(fill_emit_w), .pos(pos_w),
    .underflow(underflow)
  );

  tu_framer #(.FS_CODE(FS_CODE), .FE_CODE(FE_CODE)) u_framer (
    .clk(clk), .rst_n(rst_n), .emit(emit_w), .kind(kind_w),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_ctrl(out_ctrl)
  );

endmodule

// File: rtl/tu_packetizer_chk.sv
module tu_packetizer_chk #(
  parameter int         POS_W   = 8,
  parameter logic [7:0] FE_CODE = 8'hFB
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_start,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic [15:0]      out_data,
  input logic [1:0]       out_ctrl,
  input logic             underflow,
  input logic [POS_W-1:0] grant,
  input logic [POS_W-1:0] tw,
  input logic [1:0]       mk,
  input logic [POS_W-1:0] pos,
  input logic             fill_emit,
  input logic             tu_last
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == 16'h0 && out_ctrl == 2'b00));

  p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pos < tw);

  p_grant_fit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == tw) || (int'(grant) + 2 * int'(mk) <= int'(tw)));

  p_ctrl_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_ctrl == 2'b00 || out_ctrl == 2'b11);

  p_fe_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_emit && tu_last) |=> (out_ctrl == 2'b11 && out_data == {FE_CODE, FE_CODE}));

  p_stall_no_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> !out_valid);

  p_no_ready_in_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_emit && !tu_last && !line_start) |=> !in_ready);

  p_underflow_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid && !line_start) |=> underflow);

  p_underflow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !line_start) |=> underflow);

endmodule

bind tu_packetizer tu_packetizer_chk #(.POS_W(POS_W), .FE_CODE(FE_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
  .out_ctrl(out_ctrl), .underflow(underflow), .grant(grant_w), .tw(tw_w),
  .mk(mk_w), .pos(pos_w), .fill_emit(fill_emit_w), .tu_last(tu_last_w)
);

// File: tb/tu_packetizer_test.sv
module tu_packetizer_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic [1:0]  lane_sel = 2'd0;
  logic [7:0]  ratio_int = 8'd0;
  logic [7:0]  ratio_frac = 8'd0;
  logic [15:0] in_data = 16'h0;
  logic        in_valid = 1'b0;
  logic        line_end = 1'b0;
  logic        in_ready, out_valid, underflow;
  logic [15:0] out_data;
  logic [1:0]  out_ctrl;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [17:0] exp_q[$];
  logic [17:0] got_q[$];

  tu_packetizer uut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .lane_sel(lane_sel),
    .ratio_int(ratio_int), .ratio_frac(ratio_frac), .in_data(in_data),
    .in_valid(in_valid), .line_end(line_end), .in_ready(in_ready),
    .out_data(out_data), .out_ctrl(out_ctrl), .out_valid(out_valid),
    .underflow(underflow)
  );

  always #(PERIOD / 2) clk = ~clk;

  always begin
    @(posedge clk);
    #1;
    if (out_valid) got_q.push_back({out_ctrl, out_data});
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] dat(int base, int i);
    return 16'(base + i * 37);
  endfunction

  // Expected output of one line, built directly from the requirements.
  task automatic build(int w, int gi, int gf, int ls, int base);
    int tw, m, i, k, g, d, fi;
    tw = 32 * ((ls == 0) ? 1 : (ls == 1) ? 2 : 4);
    m  = (ls >= 2) ? 2 : 1;
    i  = 0;
    k  = 0;
    exp_q.delete();
    while (1) begin
      g = gi + ((k + 1) * gf) / 256 - (k * gf) / 256;
      if (g >= tw) g = tw;
      else if (g > tw - 2 * m) g = tw - 2 * m;
      d  = 0;
      fi = 0;
      for (int p = 0; p < tw; p++) begin
        if (d < g && i < w) begin
          exp_q.push_back({2'b00, dat(base, i)});
          i++;
          d++;
        end else begin
          if (p >= tw - m)  exp_q.push_back({2'b11, 16'hFBFB});
          else if (fi < m)  exp_q.push_back({2'b11, 16'hF7F7});
          else              exp_q.push_back(18'h0);
          fi++;
        end
      end
      if (i >= w) break;
      k++;
    end
  endtask

  task automatic drive_line(int w, int gi, int gf, int ls, int base, bit gaps, bit chg);
    @(negedge clk);
    ratio_int  = 8'(gi);
    ratio_frac = 8'(gf);
    lane_sel   = 2'(ls);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    if (chg) begin
      ratio_int  = 8'd3;
      ratio_frac = 8'hF0;
      lane_sel   = 2'd2;
    end
    for (int i = 0; i < w; i++) begin
      if (gaps && (i % 9) == 4) begin
        in_valid = 1'b0;
        line_end = 1'b0;
        repeat (3) @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = dat(base, i);
      line_end = (i == w - 1);
      forever begin
        bit r;
        #1;
        r = in_ready;
        @(negedge clk);
        if (r) break;
      end
    end
    in_valid = 1'b0;
    line_end = 1'b0;
    in_data  = 16'h0;
    repeat (300) @(negedge clk);
  endtask

  task automatic run_line(int w, int gi, int gf, int ls, int base, bit gaps, bit chg, string tag);
    int bad;
    build(w, gi, gf, ls, base);
    got_q.delete();
    drive_line(w, gi, gf, ls, base, gaps, chg);
    check(got_q.size() == exp_q.size(), tag, "output word count", got_q.size(), exp_q.size());
    bad = -1;
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++) begin
      if (got_q[i] !== exp_q[i]) begin
        bad = i;
        break;
      end
    end
    if (bad >= 0)
      check(1'b0, tag, $sformatf("word %0d {ctrl,data}", bad), int'(got_q[bad]), int'(exp_q[bad]));
    else
      check(1'b1, tag, "words", 0, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b0, "R1", "in_ready after reset", in_ready, 0);
    check(underflow == 1'b0, "R1", "underflow after reset", underflow, 0);
    check(out_data == 16'h0 && out_ctrl == 2'b00, "R1", "idle data", out_data, 0);
  endtask

  task automatic t_basic;
    run_line(70, 20, 0, 0, 16'h100, 1'b0, 1'b0, "R5 R6");
    check(in_ready == 1'b0 && out_valid == 1'b0, "R9", "idle after line", {in_ready, out_valid}, 0);
    check(underflow == 1'b0, "R8", "no stall no underflow", underflow, 0);
  endtask

  task automatic t_fraction;
    run_line(120, 10, 8'h80, 0, 16'h200, 1'b0, 1'b0, "R3");
    run_line(200, 40, 8'h55, 1, 16'h300, 1'b0, 1'b0, "R2 R3");
  endtask

  task automatic t_lanes;
    run_line(300, 100, 8'h33, 2, 16'h400, 1'b0, 1'b0, "R2 R5");
    run_line(150, 60, 8'h00, 3, 16'h500, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_full_and_clamp;
    run_line(80, 32, 0, 0, 16'h600, 1'b0, 1'b0, "R4");
    run_line(70, 200, 0, 0, 16'h650, 1'b0, 1'b0, "R4");
    run_line(60, 31, 0, 0, 16'h700, 1'b0, 1'b0, "R4");
  endtask

  task automatic t_stall;
    run_line(90, 20, 8'h40, 0, 16'h800, 1'b1, 1'b0, "R7");
    check(underflow == 1'b1, "R8", "underflow after stall", underflow, 1);
    run_line(40, 12, 0, 0, 16'h900, 1'b0, 1'b0, "R8");
    check(underflow == 1'b0, "R8", "underflow cleared by line_start", underflow, 0);
  endtask

  task automatic t_cfg_change;
    run_line(100, 18, 8'h20, 0, 16'hA00, 1'b0, 1'b1, "R10");
  endtask

  task automatic t_line_end;
    run_line(40, 20, 0, 0, 16'hB00, 1'b0, 1'b0, "R9");
    check(in_ready == 1'b0 && out_valid == 1'b0, "R9", "idle after exact end", {in_ready, out_valid}, 0);
  endtask

  task automatic t_acc_restart;
    run_line(50, 9, 8'hC0, 0, 16'hC00, 1'b0, 1'b0, "R11");
    run_line(50, 9, 8'hC0, 0, 16'hC00, 1'b0, 1'b0, "R11");
  endtask

  initial begin
    #(PERIOD * 190000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R9 watchdog expired: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_fraction();
    t_lanes();
    t_full_and_clamp();
    t_stall();
    t_cfg_change();
    t_line_end();
    t_acc_restart();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule